// File: doc/BRIEF.md
# Control-Structure Pointer and Launch-State Tracker

This block keeps the state that a processor core holds about its virtual-machine control structures. A small table records which structures are active, and for each one whether it is in the clear or the launched state. A separate register names the current structure, if there is one. Commands arrive one per cycle with a 64-bit physical address. Each command is answered one cycle later with a pass or fail result.

There are five commands. Load makes a structure current and adds it to the table. Store reads the current pointer back. Clear removes a structure from the table. Launch and resume check the current structure's launch state before the core switches into a guest. The table is a fully associative lookup on the address, and its size is a parameter. When no structure is current, the pointer output reads as all ones.

Top module: `ctl_ptr_tracker`

## Requirements
- R1: After reset no structure is current, `cur_ptr` reads 64'hFFFF_FFFF_FFFF_FFFF, `rsp_valid` is 0 and the table is empty. After reset, ENTRIES distinct loads all succeed.
- R2: A command on `cmd_valid` is answered in the next cycle with `rsp_valid`=1 and exactly one of `rsp_ok`/`rsp_err`. The `cmd_op` encodings are 1 load, 2 store, 3 clear, 4 launch and 5 resume. Any other code answers with `rsp_err`=1 and changes nothing.
- R3: A load or clear whose address has any of bits 11:0 set, or any bit at or above PA_WIDTH set, answers `rsp_err`=1 and changes no state.
- R4: A valid load makes the addressed structure current (`cur_ptr` equals the address from the cycle of the response on). Other active structures stay active and keep their launch state. A load of an address that is already active keeps that address's launch state and does not take a new table slot.
- R5: A structure newly added by load is in the clear state. Launch passes only when the current structure is clear, and it sets the structure to launched. Resume passes only when the current structure is launched and leaves it launched. A failing launch or resume changes nothing.
- R6: A valid clear answers `rsp_ok`. If the address is active, the structure leaves the table and returns to the clear state. If it was current, `cur_ptr` reads all ones afterwards. Clearing an address that is not active changes nothing.
- R7: Store answers `rsp_ok`, and `rsp_ptr` is set to the current pointer, or to all ones when no structure is current.
- R8: Launch or resume with no current structure answers `rsp_err`=1 and changes nothing.
- R9: A load of an address that is not active, made while all ENTRIES slots are in use, answers `rsp_err`=1 and `rsp_full`=1. It changes no state. `rsp_full` is 0 on every other response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 64 | Structure physical address |
| cur_ptr | output | 64 | Current pointer, all ones if none |
| rsp_valid | output | 1 | Response for last cycle's command |
| rsp_ok | output | 1 | Command passed |
| rsp_err | output | 1 | Command failed |
| rsp_full | output | 1 | Load failed because the table is full |
| rsp_ptr | output | 64 | Pointer returned by the last store |

## Verification
A wrong launch bit stays hidden until the affected structure is current again. It then shows up as a launch or resume answering the opposite result, one cycle after that command. A lost or duplicated table entry shows up in two ways: a load that should be refused passes, or the capacity error appears too early. This can take several commands to expose, so the bench walks long mixed sequences over more addresses than the table has slots. It predicts every response and every value of `cur_ptr`, and each wrong current-pointer register is visible on `cur_ptr` in the cycle after the command.

// File: rtl/ctl_ptr_tracker.sv
module ctl_ptr_tracker #(
  parameter int ENTRIES  = 4,
  parameter int PA_WIDTH = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [63:0] cmd_addr,
  output logic [63:0] cur_ptr,
  output logic        rsp_valid,
  output logic        rsp_ok,
  output logic        rsp_err,
  output logic        rsp_full,
  output logic [63:0] rsp_ptr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [63:0] BAD_MASK = ~((64'd1 << PA_WIDTH) - 64'd1) | 64'hFFF;
  localparam logic [2:0] OP_LOAD = 3'd1, OP_STORE = 3'd2, OP_CLEAR = 3'd3,
                         OP_LAUNCH = 3'd4, OP_RESUME = 3'd5;

  logic [ENTRIES-1:0] ent_vld, ent_lch, hit_vec;
  logic [63:0]        ent_addr [ENTRIES];
  logic               cur_vld;
  logic [IDX_W-1:0]   cur_idx, hit_idx, free_idx;

  wire addr_ok = ~|(cmd_addr & BAD_MASK);
  wire hit_any = |hit_vec;
  wire tbl_full = &ent_vld;
  wire cur_lch = ent_lch[cur_idx];

  assign cur_ptr = cur_vld ? ent_addr[cur_idx] : '1;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hit_vec[i] = ent_vld[i] && (ent_addr[i] == cmd_addr);
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld   <= '0;
      ent_lch   <= '0;
      cur_vld   <= 1'b0;
      cur_idx   <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_full  <= 1'b0;
      rsp_ptr   <= '1;
      for (int i = 0; i < ENTRIES; i++) ent_addr[i] <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_full  <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_LOAD: begin
            if (!addr_ok) rsp_err <= 1'b1;
            else if (hit_any) begin
              cur_vld <= 1'b1;
              cur_idx <= hit_idx;
              rsp_ok  <= 1'b1;
            end else if (tbl_full) begin
              rsp_err  <= 1'b1;
              rsp_full <= 1'b1;
            end else begin
              ent_vld[free_idx]  <= 1'b1;
              ent_lch[free_idx]  <= 1'b0;
              ent_addr[free_idx] <= cmd_addr;
              cur_vld <= 1'b1;
              cur_idx <= free_idx;
              rsp_ok  <= 1'b1;
            end
          end
          OP_STORE: begin
            rsp_ptr <= cur_ptr;
            rsp_ok  <= 1'b1;
          end
          OP_CLEAR: begin
            if (!addr_ok) rsp_err <= 1'b1;
            else begin
              rsp_ok <= 1'b1;
              if (hit_any) begin
                ent_vld[hit_idx] <= 1'b0;
                ent_lch[hit_idx] <= 1'b0;
                if (cur_vld && cur_idx == hit_idx) cur_vld <= 1'b0;
              end
            end
          end
          OP_LAUNCH: begin
            if (cur_vld && !cur_lch) begin
              ent_lch[cur_idx] <= 1'b1;
              rsp_ok <= 1'b1;
            end else rsp_err <= 1'b1;
          end
          OP_RESUME: begin
            if (cur_vld && cur_lch) rsp_ok <= 1'b1;
            else rsp_err <= 1'b1;
          end
          default: rsp_err <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_ptr_tracker_chk.sv
module ctl_ptr_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic [63:0] cmd_addr,
  input logic [63:0] cur_ptr,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic        rsp_err,
  input logic        rsp_full,
  input logic [63:0] rsp_ptr
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid); // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok != rsp_err)); // R2
  AST_MISALIGNED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd3) && cmd_addr[11:0] != 12'd0)
      |=> (rsp_err && $stable(cur_ptr))); // R3
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ptr != '1) |-> (cur_ptr[11:0] == 12'd0)); // R4
  AST_NO_CUR_ENTRY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5) && cur_ptr == '1)
      |=> (rsp_err && cur_ptr == '1)); // R8
  AST_STORE_RETURNS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (rsp_ok && rsp_ptr == $past(cur_ptr))); // R7
  AST_FULL_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> (rsp_err && $stable(cur_ptr))); // R9
endmodule

bind ctl_ptr_tracker ctl_ptr_tracker_chk chk_i (.*);

// File: tb/ctl_ptr_tracker_tb_top.sv
module ctl_ptr_tracker_tb_top;
  localparam int ENTRIES = 4;
  localparam int PA_WIDTH = 40;
  localparam int NADDR = 7;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [63:0] cmd_addr = '0;
  logic [63:0] cur_ptr, rsp_ptr;
  logic rsp_valid, rsp_ok, rsp_err, rsp_full;

  int checks = 0, errors = 0;
  bit m_act [5];
  bit m_lch [5];
  int m_cur = -1;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  ctl_ptr_tracker #(.ENTRIES(ENTRIES), .PA_WIDTH(PA_WIDTH)) dut_i (.*);

  function automatic logic [63:0] addr_of(int k);
    if (k < 5) return 64'(k + 1) << 12;
    if (k == 5) return 64'h5010;
    return (64'd1 << PA_WIDTH) | 64'h3000;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [2:0] op, int k);
    logic [63:0] a = addr_of(k);
    bit e_ok = 0, e_full = 0;
    int cnt = 0;
    string tag = "R2";
    logic [63:0] e_ptr = (m_cur >= 0) ? addr_of(m_cur) : '1;
    for (int i = 0; i < 5; i++) cnt += int'(m_act[i]);
    case (op)
      3'd1: if (k >= 5) tag = "R3";
            else if (m_act[k]) begin tag = "R4"; e_ok = 1; m_cur = k; end
            else if (cnt == ENTRIES) begin tag = "R9"; e_full = 1; end
            else begin tag = "R4"; e_ok = 1; m_act[k] = 1; m_lch[k] = 0; m_cur = k; end
      3'd2: begin tag = "R7"; e_ok = 1; end
      3'd3: if (k >= 5) tag = "R3";
            else begin
              tag = "R6"; e_ok = 1;
              m_act[k] = 0; m_lch[k] = 0;
              if (m_cur == k) m_cur = -1;
            end
      3'd4: if (m_cur < 0) tag = "R8";
            else begin tag = "R5"; if (!m_lch[m_cur]) begin e_ok = 1; m_lch[m_cur] = 1; end end
      3'd5: if (m_cur < 0) tag = "R8";
            else begin tag = "R5"; e_ok = m_lch[m_cur]; end
      default: tag = "R2";
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    chk({tag, " rsp_ok"}, 64'(rsp_ok), 64'(e_ok));
    chk({tag, " rsp_err"}, 64'(rsp_err), 64'(!e_ok));
    chk({tag, " rsp_full"}, 64'(rsp_full), 64'(e_full));
    chk({tag, " cur_ptr"}, cur_ptr, (m_cur >= 0) ? addr_of(m_cur) : '1);
    if (op == 3'd2) chk("R7 rsp_ptr", rsp_ptr, e_ptr);
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur_ptr", cur_ptr, '1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    run(3'd2, 0);
    run(3'd4, 0);
    run(3'd5, 0);
    for (int k = 0; k < ENTRIES; k++) run(3'd1, k);
    run(3'd1, 4);
    run(3'd1, 5);
    run(3'd1, 6);
    run(3'd4, 0);
    run(3'd4, 0);
    run(3'd5, 0);
    run(3'd1, 1);
    run(3'd5, 1);
    run(3'd1, 3);
    run(3'd3, 3);
    run(3'd2, 0);
    run(3'd1, 3);
    run(3'd4, 0);
    run(3'd0, 0);
    run(3'd7, 2);
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < NADDR; k++) run(3'(op), k);
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run(3'(1 + (seed[18:16] % 5)), int'(seed[27:24]) % NADDR);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule